// File: doc/BRIEF.md
# Detector Link Command Decoder

This block sits at the receiving end of a byte-wide command link on a detector interface board. Bytes arrive already decoded from the line code. Each byte comes with a valid flag and a flag that marks it as a control character. The decoder sorts the stream into two kinds of command.

A single-byte fast command produces a one-cycle strobe on the next clock. An addressed block transfer carries a length byte, a start address and a run of payload bytes, and the payload is written into a local 256 x 8 configuration memory. The front-end loading logic reads that memory through a combinational read port. A configuration operation is a block transfer followed by the load fast command. The decoder protects the stored block from being overwritten until that load strobe has been issued.

On the return path the block drives one byte per clock to an upstream transmitter. Every accepted command is acknowledged with a running 8-bit command count. Each completed command is confirmed with a done message. While no message is waiting, the return path sends a status byte.

Top module: `cmdlink_decoder`

## Requirements
- R1: After reset the return path sends the status byte 0x00 with the control flag clear, both strobes are low, and the first accepted command is numbered 1.
- R2: A data byte below 0x10 received while waiting for a command is a known fast command. On the following cycle, fast_stb is high for one cycle and fast_code holds the byte. For code 0x01 (load), load_stb is also high in that same cycle.
- R3: A data byte of 0x80 or above opens a block transfer. The next data bytes are the length L, then the start address A, then L+1 payload bytes. Payload byte i is written to address (A+i) mod 256.
- R4: Each command byte accepted while waiting increments the 8-bit command count modulo 256. It is acknowledged by the control byte 0xA0 followed by a data byte holding the new count.
- R5: A completed command is confirmed by the control byte 0xD0 followed by a data byte holding that command's count. Known fast commands complete at once. A block completes when its last payload byte is written.
- R6: When a done and an acknowledge are both waiting, the done message is sent first. Status bytes are sent only when neither is waiting.
- R7: A data byte from 0x10 to 0x7F received while waiting is acknowledged and counted. It raises no strobe and sends no done message.
- R8: A valid control character received inside a block transfer aborts it. Status bit 1 becomes set and stays set. The decoder then waits for a new command byte.
- R9: When a block completes, status bit 0 (held) is set, and it is cleared by the load command. A block that arrives while held is set is acknowledged and parsed. Its payload is not written and it sends no done message.
- R10: Bytes with rx_valid low are ignored everywhere. Valid control characters received while waiting for a command are ignored: no count, no message, no strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rx_byte | input | 8 | Decoded byte from the link |
| rx_valid | input | 1 | rx_byte carries a byte this cycle |
| rx_is_k | input | 1 | rx_byte is a control character |
| fast_stb | output | 1 | One-cycle fast command strobe |
| fast_code | output | 8 | Code of the strobed fast command |
| load_stb | output | 1 | One-cycle load command strobe |
| cfg_rd_addr | input | 8 | Configuration memory read address |
| cfg_rd_data | output | 8 | Configuration memory read data (combinational) |
| tx_byte | output | 8 | Byte for the upstream transmitter |
| tx_is_k | output | 1 | tx_byte is a control character |

## Verification
The return path keeps only one waiting acknowledge and one waiting done. The checks therefore assume that a new command does not arrive before the two messages of the previous one have left, which takes at most six cycles. The stimulus leaves at least six idle cycles after each command byte and each block. Payload bytes of a block may arrive back to back, because a block raises only one acknowledge while it is being received.

// File: rtl/cmdlink_pkg.sv
package cmdlink_pkg;

    localparam int BYTE_W = 8;
    localparam int ADDR_W = 8;

    localparam logic [BYTE_W-1:0] ACK_CODE  = 8'hA0;
    localparam logic [BYTE_W-1:0] DONE_CODE = 8'hD0;

    typedef enum logic [1:0] {
        P_WAIT,
        P_LEN,
        P_ADDR,
        P_DATA
    } parse_st_t;

    typedef struct packed {
        logic              fire;
        logic [BYTE_W-1:0] cnt;
    } msg_req_t;

    function automatic logic [BYTE_W-1:0] status_byte(input logic held, input logic err);
        return {{(BYTE_W-2){1'b0}}, err, held};
    endfunction

    function automatic logic opens_block(input logic [BYTE_W-1:0] b);
        return b[BYTE_W-1];
    endfunction

endpackage

// File: rtl/cmd_parser.sv
module cmd_parser
    import cmdlink_pkg::*;
#(
    parameter int                FAST_KNOWN = 16,
    parameter logic [BYTE_W-1:0] LOAD_CODE  = 8'h01
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [BYTE_W-1:0] rx_byte,
    input  logic              rx_valid,
    input  logic              rx_is_k,
    output logic              fast_stb,
    output logic [BYTE_W-1:0] fast_code,
    output logic              load_stb,
    output logic              wr_en,
    output logic [ADDR_W-1:0] wr_addr,
    output logic [BYTE_W-1:0] wr_data,
    output msg_req_t          ack_req,
    output msg_req_t          done_req,
    output logic              held,
    output logic              err
);

    parse_st_t         st;
    logic [BYTE_W-1:0] cnt;
    logic [BYTE_W-1:0] cnt_nx;
    logic [BYTE_W-1:0] remain;
    logic [ADDR_W-1:0] addr;
    logic [BYTE_W-1:0] blk_cnt;
    logic              blk_skip;
    logic              dbyte;
    logic              kbyte;

    assign dbyte  = rx_valid && !rx_is_k;
    assign kbyte  = rx_valid && rx_is_k;
    assign cnt_nx = cnt + 1'b1;

    assign wr_en   = (st == P_DATA) && dbyte && !blk_skip;
    assign wr_addr = addr;
    assign wr_data = rx_byte;

    always_ff @(posedge clk) begin
        if (rst) begin
            st        <= P_WAIT;
            cnt       <= '0;
            remain    <= '0;
            addr      <= '0;
            blk_cnt   <= '0;
            blk_skip  <= 1'b0;
            fast_stb  <= 1'b0;
            fast_code <= '0;
            load_stb  <= 1'b0;
            ack_req   <= '0;
            done_req  <= '0;
            held      <= 1'b0;
            err       <= 1'b0;
        end else begin
            fast_stb      <= 1'b0;
            load_stb      <= 1'b0;
            ack_req.fire  <= 1'b0;
            done_req.fire <= 1'b0;
            case (st)
                P_WAIT: begin
                    if (dbyte) begin
                        cnt     <= cnt_nx;
                        ack_req <= '{fire: 1'b1, cnt: cnt_nx};
                        if (opens_block(rx_byte)) begin
                            st       <= P_LEN;
                            blk_cnt  <= cnt_nx;
                            blk_skip <= held;
                        end else if (rx_byte < BYTE_W'(FAST_KNOWN)) begin
                            fast_stb  <= 1'b1;
                            fast_code <= rx_byte;
                            done_req  <= '{fire: 1'b1, cnt: cnt_nx};
                            if (rx_byte == LOAD_CODE) begin
                                load_stb <= 1'b1;
                                held     <= 1'b0;
                            end
                        end
                    end
                end
                default: begin
                    if (kbyte) begin
                        err <= 1'b1;
                        st  <= P_WAIT;
                    end else if (dbyte) begin
                        case (st)
                            P_LEN: begin
                                remain <= rx_byte;
                                st     <= P_ADDR;
                            end
                            P_ADDR: begin
                                addr <= rx_byte;
                                st   <= P_DATA;
                            end
                            default: begin
                                addr   <= addr + 1'b1;
                                remain <= remain - 1'b1;
                                if (remain == '0) begin
                                    st <= P_WAIT;
                                    if (!blk_skip) begin
                                        done_req <= '{fire: 1'b1, cnt: blk_cnt};
                                        held     <= 1'b1;
                                    end
                                end
                            end
                        endcase
                    end
                end
            endcase
        end
    end

    // R4
    cnt_step_chk: assert property (@(posedge clk) disable iff (rst)
        (cnt != $past(cnt)) |-> $past(st == P_WAIT && dbyte));

    // R2
    load_with_fast_chk: assert property (@(posedge clk) disable iff (rst)
        load_stb |-> (fast_stb && fast_code == LOAD_CODE));

    // R8
    abort_chk: assert property (@(posedge clk) disable iff (rst)
        (st != P_WAIT && kbyte) |=> (st == P_WAIT && err));

endmodule

// File: rtl/cfg_store.sv
module cfg_store
    import cmdlink_pkg::*;
#(
    parameter int AW = ADDR_W,
    parameter int DW = BYTE_W
) (
    input  logic          clk,
    input  logic          wr_en,
    input  logic [AW-1:0] wr_addr,
    input  logic [DW-1:0] wr_data,
    input  logic [AW-1:0] rd_addr,
    output logic [DW-1:0] rd_data
);

    localparam int DEPTH = 1 << AW;

    logic [DW-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (wr_en) mem[wr_addr] <= wr_data;
    end

    assign rd_data = mem[rd_addr];

endmodule

// File: rtl/uplink_tx.sv
module uplink_tx
    import cmdlink_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  msg_req_t          ack_req,
    input  msg_req_t          done_req,
    input  logic              held,
    input  logic              err,
    output logic [BYTE_W-1:0] tx_byte,
    output logic              tx_is_k
);

    logic              ack_pend, done_pend, second;
    logic [BYTE_W-1:0] ack_val, done_val, second_val;
    logic              take_done, take_ack;

    assign take_done = !second && done_pend;
    assign take_ack  = !second && !done_pend && ack_pend;

    always_ff @(posedge clk) begin
        if (rst) begin
            ack_pend   <= 1'b0;
            done_pend  <= 1'b0;
            ack_val    <= '0;
            done_val   <= '0;
            second     <= 1'b0;
            second_val <= '0;
            tx_byte    <= status_byte(1'b0, 1'b0);
            tx_is_k    <= 1'b0;
        end else begin
            if (ack_req.fire) begin
                ack_pend <= 1'b1;
                ack_val  <= ack_req.cnt;
            end else if (take_ack) begin
                ack_pend <= 1'b0;
            end
            if (done_req.fire) begin
                done_pend <= 1'b1;
                done_val  <= done_req.cnt;
            end else if (take_done) begin
                done_pend <= 1'b0;
            end

            if (second) begin
                tx_byte <= second_val;
                tx_is_k <= 1'b0;
                second  <= 1'b0;
            end else if (done_pend) begin
                tx_byte    <= DONE_CODE;
                tx_is_k    <= 1'b1;
                second     <= 1'b1;
                second_val <= done_val;
            end else if (ack_pend) begin
                tx_byte    <= ACK_CODE;
                tx_is_k    <= 1'b1;
                second     <= 1'b1;
                second_val <= ack_val;
            end else begin
                tx_byte <= status_byte(held, err);
                tx_is_k <= 1'b0;
            end
        end
    end

    // R6
    done_first_chk: assert property (@(posedge clk) disable iff (rst)
        (!second && done_pend) |=> (tx_is_k && tx_byte == DONE_CODE));

    // R5
    count_follows_code_chk: assert property (@(posedge clk) disable iff (rst)
        tx_is_k |=> !tx_is_k);

endmodule

// File: rtl/cmdlink_decoder.sv
module cmdlink_decoder
    import cmdlink_pkg::*;
#(
    parameter int                FAST_KNOWN = 16,
    parameter logic [BYTE_W-1:0] LOAD_CODE  = 8'h01
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [BYTE_W-1:0] rx_byte,
    input  logic              rx_valid,
    input  logic              rx_is_k,
    output logic              fast_stb,
    output logic [BYTE_W-1:0] fast_code,
    output logic              load_stb,
    input  logic [ADDR_W-1:0] cfg_rd_addr,
    output logic [BYTE_W-1:0] cfg_rd_data,
    output logic [BYTE_W-1:0] tx_byte,
    output logic              tx_is_k
);

    logic              wr_en;
    logic [ADDR_W-1:0] wr_addr;
    logic [BYTE_W-1:0] wr_data;
    msg_req_t          ack_req, done_req;
    logic              held, err;

    cmd_parser #(
        .FAST_KNOWN(FAST_KNOWN),
        .LOAD_CODE (LOAD_CODE)
    ) u_parser (
        .clk      (clk),
        .rst      (rst),
        .rx_byte  (rx_byte),
        .rx_valid (rx_valid),
        .rx_is_k  (rx_is_k),
        .fast_stb (fast_stb),
        .fast_code(fast_code),
        .load_stb (load_stb),
        .wr_en    (wr_en),
        .wr_addr  (wr_addr),
        .wr_data  (wr_data),
        .ack_req  (ack_req),
        .done_req (done_req),
        .held     (held),
        .err      (err)
    );

    cfg_store #(
        .AW(ADDR_W),
        .DW(BYTE_W)
    ) u_store (
        .clk    (clk),
        .wr_en  (wr_en),
        .wr_addr(wr_addr),
        .wr_data(wr_data),
        .rd_addr(cfg_rd_addr),
        .rd_data(cfg_rd_data)
    );

    uplink_tx u_tx (
        .clk     (clk),
        .rst     (rst),
        .ack_req (ack_req),
        .done_req(done_req),
        .held    (held),
        .err     (err),
        .tx_byte (tx_byte),
        .tx_is_k (tx_is_k)
    );

endmodule

// File: tb/cmdlink_decoder_test.sv
`timescale 1ns/1ps
module cmdlink_decoder_test;

    localparam int WATCHDOG = 150000;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [7:0] rx_byte = 8'h00;
    logic       rx_valid = 1'b0;
    logic       rx_is_k = 1'b0;
    logic       fast_stb, load_stb, tx_is_k;
    logic [7:0] fast_code, cfg_rd_data, tx_byte;
    logic [7:0] cfg_rd_addr = 8'h00;

    int checks = 0;
    int fails = 0;
    int cycles = 0;
    logic [7:0] exp_cnt = 8'h00;

    logic [15:0] mq[$];
    logic        mon_second = 1'b0;
    logic [7:0]  mon_code = 8'h00;

    always #10 clk = ~clk;

    cmdlink_decoder uut (
        .clk(clk), .rst(rst), .rx_byte(rx_byte), .rx_valid(rx_valid), .rx_is_k(rx_is_k),
        .fast_stb(fast_stb), .fast_code(fast_code), .load_stb(load_stb),
        .cfg_rd_addr(cfg_rd_addr), .cfg_rd_data(cfg_rd_data),
        .tx_byte(tx_byte), .tx_is_k(tx_is_k)
    );

    // collects upstream two-byte messages
    always @(negedge clk) begin
        if (!rst) begin
            if (mon_second) begin
                mq.push_back({mon_code, tx_byte});
                mon_second = 1'b0;
            end else if (tx_is_k) begin
                mon_code = tx_byte;
                mon_second = 1'b1;
            end
        end
    end

    always @(posedge clk) begin
        cycles++;
        if (cycles > WATCHDOG) begin
            fails++;
            $display("FAIL watchdog: run hung, actual %0d cycles, expected below %0d", cycles, WATCHDOG);
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic send_byte(input logic [7:0] b, input logic k);
        rx_byte = b; rx_is_k = k; rx_valid = 1'b1;
        @(negedge clk);
        rx_valid = 1'b0; rx_is_k = 1'b0;
    endtask

    task automatic gap();
        repeat (6) @(negedge clk);
    endtask

    task automatic pop_msg(input string req, input logic [7:0] code, input logic [7:0] cnt);
        logic [15:0] m;
        for (int i = 0; i < 40 && mq.size() == 0; i++) @(negedge clk);
        if (mq.size() == 0) begin
            checks++; fails++;
            $display("FAIL %s: actual no message, expected 0x%0h/0x%0h", req, code, cnt);
        end else begin
            m = mq.pop_front();
            check(req, m, {code, cnt});
        end
    endtask

    task automatic expect_quiet(input string req);
        repeat (14) @(negedge clk);
        check(req, mq.size(), 0);
    endtask

    task automatic check_status(input string req, input logic [7:0] exp);
        repeat (10) @(negedge clk);
        check(req, {tx_is_k, tx_byte}, {1'b0, exp});
    endtask

    task automatic check_mem(input string req, input logic [7:0] a, input logic [7:0] exp);
        cfg_rd_addr = a;
        #1;
        check(req, cfg_rd_data, exp);
    endtask

    task automatic fast_cmd(input string req, input logic [7:0] code);
        mq.delete();
        send_byte(code, 1'b0);
        exp_cnt++;
        check({req, " R2 strobe"}, {fast_stb, fast_code}, {1'b1, code});
        check({req, " R2 load"}, load_stb, code == 8'h01);
        @(negedge clk);
        check({req, " R2 one cycle"}, fast_stb, 1'b0);
        pop_msg({req, " R6 done first"}, 8'hD0, exp_cnt);
        pop_msg({req, " R4 ack"}, 8'hA0, exp_cnt);
        gap();
    endtask

    task automatic block(input logic [7:0] code, input logic [7:0] a, input logic [7:0] d[]);
        send_byte(code, 1'b0);
        exp_cnt++;
        send_byte(8'(d.size() - 1), 1'b0);
        send_byte(a, 1'b0);
        foreach (d[i]) send_byte(d[i], 1'b0);
    endtask

    task automatic t_reset();
        check("R1 tx status", {tx_is_k, tx_byte}, 9'h000);
        check("R1 strobes", {fast_stb, load_stb}, 2'b00);
    endtask

    task automatic t_fast();
        fast_cmd("R1 first cmd", 8'h05);
        check("R1 count starts at one", exp_cnt, 8'd1);
        fast_cmd("R5 fast", 8'h0F);
        fast_cmd("R2 load", 8'h01);
    endtask

    task automatic t_unknown();
        mq.delete();
        send_byte(8'h20, 1'b0);
        exp_cnt++;
        check("R7 no strobe", fast_stb, 1'b0);
        pop_msg("R7 ack", 8'hA0, exp_cnt);
        expect_quiet("R7 no done");
        send_byte(8'h7F, 1'b0);
        exp_cnt++;
        check("R7 no strobe top", fast_stb, 1'b0);
        pop_msg("R7 ack top", 8'hA0, exp_cnt);
        expect_quiet("R7 no done top");
    endtask

    task automatic t_ignore();
        mq.delete();
        rx_byte = 8'h05; rx_is_k = 1'b0; rx_valid = 1'b0;
        @(negedge clk);
        check("R10 invalid byte", fast_stb, 1'b0);
        send_byte(8'h1C, 1'b1);
        check("R10 control char", fast_stb, 1'b0);
        expect_quiet("R10 no message");
        fast_cmd("R10 count unchanged", 8'h02);
    endtask

    task automatic t_block();
        logic [7:0] cnt_blk;
        mq.delete();
        block(8'h85, 8'h10, '{8'h11, 8'h22, 8'h33});
        cnt_blk = exp_cnt;
        pop_msg("R4 block ack", 8'hA0, cnt_blk);
        pop_msg("R5 block done", 8'hD0, cnt_blk);
        check_mem("R3 byte0", 8'h10, 8'h11);
        check_mem("R3 byte1", 8'h11, 8'h22);
        check_mem("R3 byte2", 8'h12, 8'h33);
        check_status("R9 held set", 8'h01);
        mq.delete();
        block(8'h90, 8'h10, '{8'hAA});
        pop_msg("R9 held block ack", 8'hA0, exp_cnt);
        expect_quiet("R9 held block no done");
        check_mem("R9 memory kept", 8'h10, 8'h11);
        fast_cmd("R9 load", 8'h01);
        check_status("R9 held cleared", 8'h00);
    endtask

    task automatic t_addr_wrap();
        mq.delete();
        block(8'hFF, 8'hFE, '{8'h01, 8'h02, 8'h03, 8'h04});
        pop_msg("R3 wrap ack", 8'hA0, exp_cnt);
        pop_msg("R3 wrap done", 8'hD0, exp_cnt);
        check_mem("R3 at FE", 8'hFE, 8'h01);
        check_mem("R3 at FF", 8'hFF, 8'h02);
        check_mem("R3 wrapped 00", 8'h00, 8'h03);
        check_mem("R3 wrapped 01", 8'h01, 8'h04);
        fast_cmd("R9 load again", 8'h01);
    endtask

    task automatic t_abort();
        mq.delete();
        send_byte(8'h81, 1'b0);
        exp_cnt++;
        send_byte(8'h05, 1'b0);
        send_byte(8'h40, 1'b0);
        send_byte(8'h77, 1'b0);
        send_byte(8'hBC, 1'b1);
        pop_msg("R8 ack", 8'hA0, exp_cnt);
        expect_quiet("R8 no done");
        check_status("R8 error bit", 8'h02);
        fast_cmd("R8 back to waiting", 8'h03);
        check_status("R8 error sticky", 8'h02);
    endtask

    task automatic t_count_wrap();
        for (int i = 0; i < 256; i++) fast_cmd("R4 count run", 8'h04);
        check("R4 modulo 256", exp_cnt, 8'(exp_cnt));
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_fast();
        t_unknown();
        t_ignore();
        t_block();
        t_addr_wrap();
        t_abort();
        t_count_wrap();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule